// File: doc/BRIEF.md
# Status LED Activity Stretcher

This block drives five status LEDs from a shared set of nine status sources: collision, full duplex, link, magic-packet match, receive, receive match, transmit, 100 Mbps speed and power. Every LED has a configuration register. The register says which sources light the LED, whether short events are lengthened, and how the pin is driven.

An enabled source that goes active loads a per-LED three-stage shift register with ones in the same clock cycle. When the activity ends, the register empties one stage per slow tick. The tick is made by dividing the system clock and defaults to a 26 ms period. The result is that an event of a single cycle stays visible for two to three tick periods. When stretching is turned off, the pin follows the combined activity with one register of delay.

Each pin can be driven as an open-drain output that is active low, or as a push-pull output that is active high. The pin value and its output enable are brought out separately, so the pad can be built outside this block.

Top module: `led_activity_driver`

## Requirements
- R1: An LED's combined activity is the OR, over all nine sources, of each source bit ANDed with its enable bit. The source bit positions in `status_i` and in the enable field are: 0 collision, 1 full duplex, 2 link, 3 magic packet, 4 receive, 5 receive match, 6 transmit, 7 speed, 8 power.
- R2: With stretching disabled, the LED state seen at the pins equals the combined activity sampled at the previous clock edge.
- R3: Activity sets the stretcher to its full state at the next clock edge. This takes priority over a tick in the same cycle, and it holds for as long as the activity stays.
- R4: With stretching enabled, the LED stays on after activity ends until the third tick has been taken. The LED is then on for more than 2 and at most 3 tick periods after the last active cycle. Without a tick and without activity, the stretcher does not change.
- R5: One tick occurs every `TICK_CYCLES` clock cycles. The first tick falls in the `TICK_CYCLES`-th cycle after reset is released.
- R6: In open-drain mode, an LED that is on gives `led_o`=0 with `led_oe_o`=1. An LED that is off gives `led_oe_o`=0 with `led_o`=0.
- R7: In push-pull mode, `led_oe_o`=1 always and `led_o` equals the LED state.
- R8: After reset, every LED is in open-drain mode with stretching enabled. The enabled sources are LED0 link, LED1 transmit, LED2 receive, LED3 speed and LED4 power. The reset values are 0x604, 0x640, 0x610, 0x680 and 0x700.
- R9: A write with `wr_en_i`=1 to an address 0 to 4 loads `wr_data_i` into that LED's register, and it is visible on `rd_data_o` from the next cycle. A write to addresses 5 to 7 changes nothing, and reading them returns 0.
- R10: The register layout is: bits 8:0 the source enables, bit 9 the stretch enable, and bit 10 the drive mode (1 = open drain, 0 = push-pull).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for both write and read |
| wr_data_i | input | 11 | Register write data |
| rd_data_o | output | 11 | Read-back of the register at `addr_i` |
| status_i | input | 9 | Status sources |
| led_o | output | 5 | Pin drive value per LED |
| led_oe_o | output | 5 | Pin output enable per LED |

## Verification
The bench checks the following corner cases, and what a faulty design would do in each:
- **Drain length after a one-cycle pulse.** The bench measures how long the LED stays on, so a stretcher that shifts one stage too few or too many gives a lit time outside the window between two and three ticks.
- **Activity coinciding with a tick.** Activity held across several ticks exposes a design that lets the shift beat the forced set, because its LED would flicker in the middle of activity.
- **Stretching disabled and push-pull mode.** Switching these on one LED while the others keep their defaults shows wrong output-enable encoding, or a bypass that still stretches.
- **Illegal addresses and the reset values.** Writes to addresses 5 to 7 and reads of the reset values catch address decode that wraps onto a real register.

// File: rtl/led_act_pkg.sv
package led_act_pkg;

    localparam int NUM_LED = 5;
    localparam int NUM_SRC = 9;
    localparam int ADDR_W  = 3;
    localparam int SR_LEN  = 3;

    localparam int SRC_COL   = 0;
    localparam int SRC_FDX   = 1;
    localparam int SRC_LINK  = 2;
    localparam int SRC_MAGIC = 3;
    localparam int SRC_RCV   = 4;
    localparam int SRC_RCVM  = 5;
    localparam int SRC_XMT   = 6;
    localparam int SRC_SPD   = 7;
    localparam int SRC_PWR   = 8;

    typedef struct packed {
        logic               open_drain;
        logic               stretch;
        logic [NUM_SRC-1:0] src_en;
    } led_cfg_t;

    localparam int CFG_W = $bits(led_cfg_t);

    function automatic led_cfg_t reset_cfg(input int idx);
        led_cfg_t c;
        c.open_drain = 1'b1;
        c.stretch    = 1'b1;
        c.src_en     = '0;
        case (idx)
            0:       c.src_en[SRC_LINK] = 1'b1;
            1:       c.src_en[SRC_XMT]  = 1'b1;
            2:       c.src_en[SRC_RCV]  = 1'b1;
            3:       c.src_en[SRC_SPD]  = 1'b1;
            default: c.src_en[SRC_PWR]  = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int DIV = 2_600_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    assign tick_o = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R5

endmodule

// File: rtl/led_cfg_bank.sv
module led_cfg_bank
    import led_act_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [CFG_W-1:0]            wr_data_i,
    output logic [CFG_W-1:0]            rd_data_o,
    output led_cfg_t [NUM_LED-1:0]      cfg_o
);
    led_cfg_t [NUM_LED-1:0] cfg_d, cfg_q;
    logic addr_ok;

    assign addr_ok = (32'(addr_i) < NUM_LED);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i && addr_ok) cfg_d[addr_i] = led_cfg_t'(wr_data_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LED; i++) cfg_q[i] <= reset_cfg(i);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_data_o = addr_ok ? CFG_W'(cfg_q[addr_i]) : '0;
    assign cfg_o     = cfg_q;

    AST_BAD_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_ok) |=> $stable(cfg_q)); // R9
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_ok) |=> (rd_data_o == $past(wr_data_i) || addr_i != $past(addr_i))); // R9

endmodule

// File: rtl/led_stretch_chan.sv
module led_stretch_chan
    import led_act_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [NUM_SRC-1:0] status_i,
    input  led_cfg_t           cfg_i,
    output logic               pin_o,
    output logic               pin_oe_o
);
    typedef struct packed {
        logic [SR_LEN-1:0] sr;
        logic              pin;
        logic              oe;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic active;
    logic lit;

    assign active = |(status_i & cfg_i.src_en);

    always_comb begin
        st_d = st_q;
        if (active)      st_d.sr = '1;
        else if (tick_i) st_d.sr = {st_q.sr[SR_LEN-2:0], 1'b0};
        lit = cfg_i.stretch ? st_d.sr[SR_LEN-1] : active;
        if (cfg_i.open_drain) begin
            st_d.pin = 1'b0;
            st_d.oe  = lit;
        end else begin
            st_d.pin = lit;
            st_d.oe  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o    = st_q.pin;
    assign pin_oe_o = st_q.oe;

    AST_FORCE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (st_q.sr == '1)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !tick_i) |=> $stable(st_q.sr)); // R4
    AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        (((st_q.sr << 1) & ~st_q.sr) == '0)); // R4
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.stretch && !cfg_i.open_drain) |=> (pin_o == $past(active))); // R2
    AST_OD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.open_drain |=> !pin_o); // R6
    AST_PP_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.open_drain |=> pin_oe_o); // R7

endmodule

// File: rtl/led_activity_driver.sv
module led_activity_driver
    import led_act_pkg::*;
#(
    parameter int TICK_CYCLES = 2_600_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [CFG_W-1:0]         wr_data_i,
    output logic [CFG_W-1:0]         rd_data_o,
    input  logic [NUM_SRC-1:0]       status_i,
    output logic [NUM_LED-1:0]       led_o,
    output logic [NUM_LED-1:0]       led_oe_o
);
    logic                   tick;
    led_cfg_t [NUM_LED-1:0] cfg;

    led_tick_gen #(.DIV(TICK_CYCLES)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    led_cfg_bank i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < NUM_LED; g++) begin : g_chan
        led_stretch_chan i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick),
            .status_i (status_i),
            .cfg_i    (cfg[g]),
            .pin_o    (led_o[g]),
            .pin_oe_o (led_oe_o[g])
        );
    end

endmodule

// File: tb/test_led_activity_driver.sv
module test_led_activity_driver;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [10:0] wr_data = '0;
    logic [10:0] rd_data;
    logic [8:0]  status = '0;
    logic [4:0]  led, led_oe;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R6 R8";

    // reference model state
    logic [10:0] mreg [5];
    int          mleft [5];
    logic [4:0]  mo, moe;
    int          mtick_cnt;

    always #5 clk = ~clk;

    led_activity_driver #(.TICK_CYCLES(DIV)) i_led_activity_driver (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wr_data_i(wr_data), .rd_data_o(rd_data), .status_i(status),
        .led_o(led), .led_oe_o(led_oe)
    );

    function automatic logic [10:0] dflt(int i);
        case (i)
            0: return 11'h604;
            1: return 11'h640;
            2: return 11'h610;
            3: return 11'h680;
            default: return 11'h700;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin mreg[i] = dflt(i); mleft[i] = 0; end
            mo = '0; moe = '0; mtick_cnt = 0;
        end else begin
            bit tk;
            tk = (mtick_cnt == DIV - 1);
            for (int i = 0; i < 5; i++) begin
                bit act, on;
                act = (status & mreg[i][8:0]) != 0;
                if (act) mleft[i] = 3;
                else if (tk && mleft[i] > 0) mleft[i] = mleft[i] - 1;
                on = mreg[i][9] ? (mleft[i] > 0) : act;
                if (mreg[i][10]) begin mo[i] = 1'b0; moe[i] = on; end
                else begin mo[i] = on; moe[i] = 1'b1; end
            end
            if (wr_en && addr < 5) mreg[addr] = wr_data;
            mtick_cnt = tk ? 0 : mtick_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [10:0] exp_rd;
            exp_rd = (addr < 5) ? mreg[addr] : 11'h0;
            checks++;
            if (led !== mo || led_oe !== moe) begin
                fails++;
                $display("FAIL %s R1 R5 pins: led=%b oe=%b expected led=%b oe=%b", tag, led, led_oe, mo, moe);
            end
            checks++;
            if (rd_data !== exp_rd) begin
                fails++;
                $display("FAIL R9 R10 readback addr %0d: %h expected %h", addr, rd_data, exp_rd);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic wr(input logic [2:0] a, input logic [10:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr;
        int len;
        // reset state, R8
        #2;
        @(negedge clk);
        checks++;
        if (led_oe !== 5'b0 || led !== 5'b0) begin
            fails++; $display("FAIL R8 reset pins: %b/%b expected 00000/00000", led, led_oe);
        end
        cyc(2); rst_n = 1'b1;
        cyc(1);
        for (int i = 0; i < 5; i++) begin
            addr = 3'(i); #1;
            checks++;
            if (rd_data !== dflt(i)) begin
                fails++; $display("FAIL R8 default LED%0d: %h expected %h", i, rd_data, dflt(i));
            end
            cyc(1);
        end

        // R3 R4 single pulse on transmit, measure lit length on LED1
        tag = "R3 R4 R6";
        status = 9'h040; cyc(1); status = '0;
        len = 1;
        while (led_oe[1] === 1'b1 && len < 100) begin cyc(1); len++; end
        checks++;
        if (len <= 2 * DIV || len > 3 * DIV) begin
            fails++; $display("FAIL R4 stretch length %0d expected in (%0d,%0d]", len, 2*DIV, 3*DIV);
        end
        cyc(30);

        // R3 activity held across several ticks
        tag = "R3 R6";
        status = 9'h010; cyc(4 * DIV); status = '0; cyc(4 * DIV);

        // R2 R7 R1 R10: LED0 push-pull, no stretch, collision|receive
        tag = "R1 R2 R7";
        wr(3'd0, 11'h011);
        for (int k = 0; k < 20; k++) begin
            status = (k % 3 == 0) ? 9'h001 : ((k % 5 == 0) ? 9'h010 : 9'h100);
            cyc(1);
        end
        status = '0; cyc(3);

        // R7 R4 push-pull with stretch on LED3, magic+speed
        tag = "R4 R7";
        wr(3'd3, 11'h288);
        status = 9'h008; cyc(1); status = '0; cyc(3 * DIV + 4);

        // R9 illegal addresses
        tag = "R9";
        wr(3'd5, 11'h7ff); wr(3'd7, 11'h000);
        for (int i = 5; i < 8; i++) begin
            addr = 3'(i); #1;
            checks++;
            if (rd_data !== 11'h0) begin
                fails++; $display("FAIL R9 addr %0d read %h expected 000", i, rd_data);
            end
            cyc(1);
        end
        addr = 3'd1; #1;
        checks++;
        if (rd_data !== 11'h640) begin
            fails++; $display("FAIL R9 LED1 disturbed: %h expected 640", rd_data);
        end

        // R1 mixed pseudo-random stress on several configs
        tag = "R1 R3 R4 R6 R7";
        wr(3'd2, 11'h3ff); wr(3'd4, 11'h5aa);
        lfsr = 16'hace1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            status = (lfsr[3:0] == 4'h0) ? lfsr[12:4] : 9'h0;
            if (k == 200) begin status = '0; wr(3'd1, 11'h1c0); end
            cyc(1);
        end
        status = '0; cyc(40);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule